// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the register file of a processor that handles procedure calls by moving a window instead of copying data. The windowed storage is a ring of `NWIN` windows. Each window shows three groups of `NAREA` registers: incoming arguments, private locals, and outgoing values. The outgoing group of one window is the same storage as the argument group of the next window around the ring. A caller therefore hands values to its callee just by writing them before the call. A separate group of `NAREA` shared registers can be seen from every window, and moving the window never changes it.

A current-window pointer chooses the visible window. A call moves the pointer forward by one and a return moves it back by one. A saved-window pointer marks the oldest window that is still held in the ring. When a call would make the ring wrap onto that window, the block raises an overflow trap and stalls. An outside agent then saves the oldest window through the transfer port and pulses a done strobe. When a return would leave the held windows, the block raises an underflow trap. The agent restores the caller's window and acknowledges. The block has two synchronous read ports, one write port, and a transfer port that reads or writes any register of any window by window number and slot. `NWIN` and `NAREA` must be powers of two, and `NWIN` must be at least 4.

Top module: `regwin_file`

## Requirements
- R1: The logical address is 5 bits. Addresses 0–7 select the shared registers, 8–15 the argument group, 16–23 the locals and 24–31 the outgoing group of the current window. The shared registers hold the same contents in every window.
- R2: Outgoing register i of window w is the same storage as argument register i of window (w+1) mod NWIN. The outgoing group of window NWIN-1 is the argument group of window 0.
- R3: When stall is low, a call without overflow adds one (mod NWIN) to the current pointer at that clock edge, and a return with cwp ≠ swp subtracts one. A call and a return in the same cycle are both ignored. Call and return are also ignored while stall is high.
- R4: A call with (cwp+2) mod NWIN = swp raises the overflow trap and stall from the next cycle. Both stay high, with cwp and swp unchanged, until spill-done.
- R5: Spill-done during overflow adds one to swp at that edge and drops the trap. One cycle later cwp advances and stall falls. swp changes at no other time except as R6 states.
- R6: A return with cwp = swp raises the underflow trap and stall, holding cwp, until fill-ack. swp then drops by one at that edge, and cwp drops by one on the next cycle.
- R7: Each read port returns the addressed register one clock after the address is presented. The two ports are independent.
- R8: A read and a write of the same physical register in the same cycle return the newly written value. This includes the case where the read and write reach that register through the window overlap or the transfer port.
- R9: The transfer port selects window xfer_win and slot xfer_idx (0–7 arguments, 8–15 locals). It returns that register one cycle later and writes it when xfer_we is high. A transfer write takes the write port, and a core write in the same cycle is dropped.
- R10: After reset cwp = 0, swp = 0, and both traps and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| stall_o | output | 1 | Window move in progress; call and return are ignored |
| ovf_trap_o | output | 1 | Overflow trap: the window at swp must be saved |
| unf_trap_o | output | 1 | Underflow trap: the window at swp-1 must be restored |
| spill_done_i | input | 1 | Agent finished saving the oldest window |
| fill_ack_i | input | 1 | Agent finished restoring the caller's window |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |
| rd0_addr_i | input | 5 | Read port 0 logical address |
| rd0_data_o | output | 32 | Read port 0 data, one cycle later |
| rd1_addr_i | input | 5 | Read port 1 logical address |
| rd1_data_o | output | 32 | Read port 1 data, one cycle later |
| wr_en_i | input | 1 | Core write enable |
| wr_addr_i | input | 5 | Core write logical address |
| wr_data_i | input | 32 | Core write data |
| xfer_win_i | input | 3 | Transfer port window number |
| xfer_idx_i | input | 4 | Transfer port slot within the window |
| xfer_we_i | input | 1 | Transfer port write enable |
| xfer_wdata_i | input | 32 | Transfer port write data |
| xfer_rdata_o | output | 32 | Transfer port read data, one cycle later |

## Verification
The bound checker watches the pointer controller on every cycle. It checks that calls and returns move cwp by exactly one, that overflow and underflow are entered under the right pointer relations and hold until the agent's strobe, and that swp moves only on a spill or fill. It also checks that a core read returns a same-cycle core write to the same address. Whether the address map, the physical overlap of adjacent windows, the wrap onto window 0 and the transfer-port priority work can only be seen from data: the bench writes values through one path and reads them back through another.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;

  // Logical register groups, selected by the top two address bits
  typedef enum logic [1:0] {
    AREA_GLB = 2'd0,
    AREA_ARG = 2'd1,
    AREA_LOC = 2'd2,
    AREA_OUT = 2'd3
  } area_e;

  // Window pointer controller states
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_OVF     = 3'd1,
    ST_CALLFIN = 3'd2,
    ST_UNF     = 3'd3,
    ST_RETFIN  = 3'd4
  } ctl_state_e;

endpackage

// File: rtl/regwin_xlate.sv
`timescale 1ns/1ps
// Maps a logical register address to a physical row, using the current window
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NAREA = 8,
  parameter int PW    = 8,
  localparam int IW     = $clog2(NAREA),
  localparam int WIN_W  = $clog2(NWIN),
  localparam int LA_W   = IW + 2,
  localparam int WOFF_W = WIN_W + IW + 1
) (
  input  logic [WIN_W-1:0] cwp,
  input  logic [LA_W-1:0]  laddr,
  output logic [PW-1:0]    phys
);

  logic [IW-1:0]     slot;
  area_e             area;
  logic [WIN_W-1:0]  nxt_win;
  logic [WOFF_W-1:0] woff;

  assign slot    = laddr[IW-1:0];
  assign area    = area_e'(laddr[LA_W-1 -: 2]);
  assign nxt_win = WIN_W'(cwp + 1'b1);   // wraps naturally: NWIN is a power of two

  always_comb begin
    woff = '0;
    phys = '0;
    case (area)
      AREA_GLB: phys = PW'(slot);
      AREA_ARG: begin
        woff = {cwp, 1'b0, slot};
        phys = PW'(NAREA) + PW'(woff);
      end
      AREA_LOC: begin
        woff = {cwp, 1'b1, slot};
        phys = PW'(NAREA) + PW'(woff);
      end
      default: begin // outgoing group = argument group of the next window
        woff = {nxt_win, 1'b0, slot};
        phys = PW'(NAREA) + PW'(woff);
      end
    endcase
  end

endmodule

// File: rtl/regwin_ctrl.sv
`timescale 1ns/1ps
// Current / saved window pointers with overflow and underflow handshakes
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             spill_done_i,
  input  logic             fill_ack_i,
  output logic [WIN_W-1:0] cwp,
  output logic [WIN_W-1:0] swp,
  output logic             ovf_trap,
  output logic             unf_trap,
  output logic             stall
);

  ctl_state_e       state;
  logic             do_call;
  logic             do_ret;
  logic [WIN_W-1:0] cwp_fwd;
  logic [WIN_W-1:0] cwp_bwd;
  logic [WIN_W-1:0] cwp_fwd2;

  assign do_call  = call_i & ~ret_i;
  assign do_ret   = ret_i & ~call_i;
  assign cwp_fwd  = WIN_W'(cwp + 1'b1);
  assign cwp_bwd  = WIN_W'(cwp - 1'b1);
  assign cwp_fwd2 = WIN_W'(cwp + 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      cwp   <= '0;
      swp   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (do_call) begin
            if (cwp_fwd2 == swp) state <= ST_OVF;
            else                 cwp   <= cwp_fwd;
          end else if (do_ret) begin
            if (cwp == swp) state <= ST_UNF;
            else            cwp   <= cwp_bwd;
          end
        end
        ST_OVF: begin
          if (spill_done_i) begin
            swp   <= WIN_W'(swp + 1'b1);
            state <= ST_CALLFIN;
          end
        end
        ST_CALLFIN: begin
          cwp   <= cwp_fwd;
          state <= ST_RUN;
        end
        ST_UNF: begin
          if (fill_ack_i) begin
            swp   <= WIN_W'(swp - 1'b1);
            state <= ST_RETFIN;
          end
        end
        ST_RETFIN: begin
          cwp   <= cwp_bwd;
          state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign ovf_trap = (state == ST_OVF);
  assign unf_trap = (state == ST_UNF);
  assign stall    = (state != ST_RUN);

endmodule

// File: rtl/regwin_store.sv
`timescale 1ns/1ps
// Flat register storage: one write port, NRD synchronous read ports with bypass
module regwin_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 136,
  parameter int PW    = 8,
  parameter int NRD   = 3
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [PW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][PW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == raddr[g])) q <= wdata;
      else                           q <= mem[raddr[g]];
    end
    assign rdata[g] = q;
  end

endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
// Overlapping windowed register file: top level
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NAREA = 8,
  parameter int DW    = 32,
  localparam int IW    = $clog2(NAREA),
  localparam int WIN_W = $clog2(NWIN),
  localparam int LA_W  = IW + 2,
  localparam int XI_W  = IW + 1,
  localparam int DEPTH = NAREA * (1 + 2 * NWIN),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_i,
  input  logic             ret_i,
  output logic             stall_o,
  output logic             ovf_trap_o,
  output logic             unf_trap_o,
  input  logic             spill_done_i,
  input  logic             fill_ack_i,
  output logic [WIN_W-1:0] cwp_o,
  output logic [WIN_W-1:0] swp_o,
  input  logic [LA_W-1:0]  rd0_addr_i,
  output logic [DW-1:0]    rd0_data_o,
  input  logic [LA_W-1:0]  rd1_addr_i,
  output logic [DW-1:0]    rd1_data_o,
  input  logic             wr_en_i,
  input  logic [LA_W-1:0]  wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [WIN_W-1:0] xfer_win_i,
  input  logic [XI_W-1:0]  xfer_idx_i,
  input  logic             xfer_we_i,
  input  logic [DW-1:0]    xfer_wdata_i,
  output logic [DW-1:0]    xfer_rdata_o
);

  localparam int NCORE = 3; // read 0, read 1, write

  logic [WIN_W-1:0]             cwp;
  logic [NCORE-1:0][LA_W-1:0]   laddr;
  logic [NCORE-1:0][PW-1:0]     phys;
  logic [PW-1:0]                xfer_phys;
  logic                         st_we;
  logic [PW-1:0]                st_waddr;
  logic [DW-1:0]                st_wdata;
  logic [2:0][PW-1:0]           st_raddr;
  logic [2:0][DW-1:0]           st_rdata;

  regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .spill_done_i (spill_done_i),
    .fill_ack_i   (fill_ack_i),
    .cwp          (cwp),
    .swp          (swp_o),
    .ovf_trap     (ovf_trap_o),
    .unf_trap     (unf_trap_o),
    .stall        (stall_o)
  );

  assign cwp_o = cwp;

  assign laddr[0] = rd0_addr_i;
  assign laddr[1] = rd1_addr_i;
  assign laddr[2] = wr_addr_i;

  for (genvar p = 0; p < NCORE; p++) begin : g_xl
    regwin_xlate #(.NWIN(NWIN), .NAREA(NAREA), .PW(PW)) u_xl (
      .cwp   (cwp),
      .laddr (laddr[p]),
      .phys  (phys[p])
    );
  end

  // Transfer port addresses a window directly: argument slots then locals
  assign xfer_phys = PW'(NAREA) + PW'({xfer_win_i, xfer_idx_i});

  assign st_we    = xfer_we_i | wr_en_i;
  assign st_waddr = xfer_we_i ? xfer_phys    : phys[2];
  assign st_wdata = xfer_we_i ? xfer_wdata_i : wr_data_i;

  assign st_raddr[0] = phys[0];
  assign st_raddr[1] = phys[1];
  assign st_raddr[2] = xfer_phys;

  regwin_store #(.DW(DW), .DEPTH(DEPTH), .PW(PW), .NRD(3)) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  assign rd0_data_o   = st_rdata[0];
  assign rd1_data_o   = st_rdata[1];
  assign xfer_rdata_o = st_rdata[2];

endmodule

// File: rtl/regwin_file_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the register file top
module regwin_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  parameter int LA_W = 5,
  localparam int WIN_W = $clog2(NWIN)
) (
  input logic             clk,
  input logic             rst,
  input logic             call_i,
  input logic             ret_i,
  input logic             stall_o,
  input logic             ovf_trap_o,
  input logic             unf_trap_o,
  input logic             spill_done_i,
  input logic             fill_ack_i,
  input logic [WIN_W-1:0] cwp_o,
  input logic [WIN_W-1:0] swp_o,
  input logic [LA_W-1:0]  rd0_addr_i,
  input logic [DW-1:0]    rd0_data_o,
  input logic             wr_en_i,
  input logic [LA_W-1:0]  wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic             xfer_we_i
);

  logic call_ok, ret_ok;
  assign call_ok = call_i && !ret_i && !stall_o;
  assign ret_ok  = ret_i && !call_i && !stall_o;

  p_call_adv_r3: assert property (@(posedge clk) disable iff (rst)
    call_ok && (WIN_W'(cwp_o + 2'd2) != swp_o) |=> cwp_o == WIN_W'($past(cwp_o) + 1'b1));

  p_ret_back_r3: assert property (@(posedge clk) disable iff (rst)
    ret_ok && (cwp_o != swp_o) |=> cwp_o == WIN_W'($past(cwp_o) - 1'b1));

  p_ovf_enter_r4: assert property (@(posedge clk) disable iff (rst)
    call_ok && (WIN_W'(cwp_o + 2'd2) == swp_o) |=> ovf_trap_o && stall_o && $stable(cwp_o));

  p_ovf_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_trap_o && !spill_done_i |=> ovf_trap_o && $stable(cwp_o) && $stable(swp_o));

  p_spill_adv_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_trap_o && spill_done_i |=> !ovf_trap_o && stall_o && swp_o == WIN_W'($past(swp_o) + 1'b1));

  p_swp_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !ovf_trap_o && !unf_trap_o |=> $stable(swp_o));

  p_unf_enter_r6: assert property (@(posedge clk) disable iff (rst)
    ret_ok && (cwp_o == swp_o) |=> unf_trap_o && stall_o && $stable(cwp_o));

  p_fill_back_r6: assert property (@(posedge clk) disable iff (rst)
    unf_trap_o && fill_ack_i |=> !unf_trap_o && swp_o == WIN_W'($past(swp_o) - 1'b1));

  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en_i && !xfer_we_i && (rd0_addr_i == wr_addr_i) |=> rd0_data_o == $past(wr_data_i));

  always @(posedge clk) begin
    if (!rst) begin
      p_trap_excl_r4: assert (!(ovf_trap_o && unf_trap_o));
    end
  end

endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .DW(DW), .LA_W(LA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .stall_o      (stall_o),
  .ovf_trap_o   (ovf_trap_o),
  .unf_trap_o   (unf_trap_o),
  .spill_done_i (spill_done_i),
  .fill_ack_i   (fill_ack_i),
  .cwp_o        (cwp_o),
  .swp_o        (swp_o),
  .rd0_addr_i   (rd0_addr_i),
  .rd0_data_o   (rd0_data_o),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .xfer_we_i    (xfer_we_i)
);

// File: tb/regwin_file_tb.sv
`timescale 1ns/1ps
module regwin_file_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 0, ret_i = 0, spill_done_i = 0, fill_ack_i = 0;
  logic        stall_o, ovf_trap_o, unf_trap_o;
  logic [2:0]  cwp_o, swp_o;
  logic [4:0]  rd0_addr_i = 0, rd1_addr_i = 0, wr_addr_i = 0;
  logic [31:0] rd0_data_o, rd1_data_o, wr_data_i = 0;
  logic        wr_en_i = 0;
  logic [2:0]  xfer_win_i = 0;
  logic [3:0]  xfer_idx_i = 0;
  logic        xfer_we_i = 0;
  logic [31:0] xfer_wdata_i = 0, xfer_rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regwin_file u_dut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .stall_o(stall_o),
    .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o),
    .spill_done_i(spill_done_i), .fill_ack_i(fill_ack_i),
    .cwp_o(cwp_o), .swp_o(swp_o),
    .rd0_addr_i(rd0_addr_i), .rd0_data_o(rd0_data_o),
    .rd1_addr_i(rd1_addr_i), .rd1_data_o(rd1_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .xfer_win_i(xfer_win_i), .xfer_idx_i(xfer_idx_i), .xfer_we_i(xfer_we_i),
    .xfer_wdata_i(xfer_wdata_i), .xfer_rdata_o(xfer_rdata_o)
  );

  // kind: 0 write, 1 read-and-compare, 2 call, 3 return
  localparam logic [38:0] VEC [13] = '{
    {2'd0, 5'd1,  32'h600D_0001},
    {2'd0, 5'd8,  32'h0000_A008},
    {2'd0, 5'd16, 32'h0000_B010},
    {2'd0, 5'd24, 32'h0000_C018},
    {2'd2, 5'd0,  32'h0},
    {2'd1, 5'd8,  32'h0000_C018},   // R2: callee args = caller outgoing
    {2'd0, 5'd16, 32'h1111_B010},
    {2'd1, 5'd16, 32'h1111_B010},   // R1: callee locals
    {2'd1, 5'd1,  32'h600D_0001},   // R1: shared register seen from window 1
    {2'd3, 5'd0,  32'h0},
    {2'd1, 5'd16, 32'h0000_B010},   // R1: caller locals kept
    {2'd1, 5'd24, 32'h0000_C018},   // R2: outgoing kept
    {2'd1, 5'd8,  32'h0000_A008}    // R1: caller args kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 cwp", 32'(cwp_o), 0);
    check("R10 swp", 32'(swp_o), 0);
    check("R10 traps/stall", {29'd0, ovf_trap_o, unf_trap_o, stall_o}, 0);

    // Table walk
    for (int i = 0; i < 13; i++) begin
      case (VEC[i][38:37])
        2'd0: begin
          wr_en_i = 1; wr_addr_i = VEC[i][36:32]; wr_data_i = VEC[i][31:0];
          step(); wr_en_i = 0;
        end
        2'd1: begin
          rd0_addr_i = VEC[i][36:32];
          step();
          check("R1/R2/R7 table read", rd0_data_o, VEC[i][31:0]);
        end
        2'd2: begin
          call_i = 1; step(); call_i = 0;
          check("R3 call advances", 32'(cwp_o), 1);
        end
        default: begin
          ret_i = 1; step(); ret_i = 0;
          check("R3 return goes back", 32'(cwp_o), 0);
        end
      endcase
    end

    // Six calls without trap: cwp 0 -> 6
    for (int k = 0; k < 6; k++) begin
      call_i = 1; step(); call_i = 0;
    end
    check("R3 six calls", 32'(cwp_o), 6);
    check("R4 no early trap", {31'd0, ovf_trap_o}, 0);

    // R4 overflow: (6+2) mod 8 == swp 0
    call_i = 1; step(); call_i = 0;
    check("R4 ovf raised", {30'd0, ovf_trap_o, stall_o}, 32'h3);
    check("R4 cwp held", 32'(cwp_o), 6);
    repeat (3) step();
    check("R4 ovf still held", {30'd0, ovf_trap_o, stall_o}, 32'h3);
    check("R4 swp held", 32'(swp_o), 0);
    spill_done_i = 1; step(); spill_done_i = 0;
    check("R5 swp advanced", 32'(swp_o), 1);
    check("R5 trap dropped, still stalled", {30'd0, ovf_trap_o, stall_o}, 32'h1);
    check("R5 cwp not yet", 32'(cwp_o), 6);
    step();
    check("R5 call completes", 32'(cwp_o), 7);
    check("R5 stall falls", {31'd0, stall_o}, 0);

    // R2 wrap: outgoing of window 7 is argument group of window 0
    wr_en_i = 1; wr_addr_i = 5'd24; wr_data_i = 32'hDEAD_0700;
    step(); wr_en_i = 0;
    xfer_win_i = 3'd0; xfer_idx_i = 4'd0;
    step();
    check("R2 wrap to window 0 / R9 xfer read", xfer_rdata_o, 32'hDEAD_0700);

    // R9 transfer write to window 7 local 2, core reads r18
    xfer_we_i = 1; xfer_win_i = 3'd7; xfer_idx_i = 4'd10; xfer_wdata_i = 32'h7777_0010;
    step(); xfer_we_i = 0;
    rd0_addr_i = 5'd18; step();
    check("R9 xfer write seen by core", rd0_data_o, 32'h7777_0010);

    // R9 priority: transfer and core write the same local in one cycle
    xfer_we_i = 1; xfer_win_i = 3'd7; xfer_idx_i = 4'd11; xfer_wdata_i = 32'hAAAA_0011;
    wr_en_i = 1; wr_addr_i = 5'd19; wr_data_i = 32'hBBBB_0019;
    step(); xfer_we_i = 0; wr_en_i = 0;
    rd0_addr_i = 5'd19; step();
    check("R9 transfer write wins", rd0_data_o, 32'hAAAA_0011);

    // R8 bypass across the overlap: transfer writes window 0 arg 1 while core reads r25
    xfer_we_i = 1; xfer_win_i = 3'd0; xfer_idx_i = 4'd1; xfer_wdata_i = 32'h5A5A_0025;
    rd0_addr_i = 5'd25;
    step(); xfer_we_i = 0;
    check("R8 bypass across overlap", rd0_data_o, 32'h5A5A_0025);

    // R8 bypass same address on port 1
    wr_en_i = 1; wr_addr_i = 5'd20; wr_data_i = 32'hC0DE_0020; rd1_addr_i = 5'd20;
    step(); wr_en_i = 0;
    check("R8 bypass port 1", rd1_data_o, 32'hC0DE_0020);

    // R7 two ports together
    rd0_addr_i = 5'd18; rd1_addr_i = 5'd25; step();
    check("R7 port 0", rd0_data_o, 32'h7777_0010);
    check("R7 port 1", rd1_data_o, 32'h5A5A_0025);

    // R3 call and return together are ignored
    call_i = 1; ret_i = 1; step(); call_i = 0; ret_i = 0;
    check("R3 simultaneous ignored", 32'(cwp_o), 7);

    // Return down to cwp 1 (swp is 1)
    for (int k = 0; k < 6; k++) begin
      ret_i = 1; step(); ret_i = 0;
    end
    check("R3 returns", 32'(cwp_o), 1);

    // R6 underflow
    ret_i = 1; step(); ret_i = 0;
    check("R6 unf raised", {30'd0, unf_trap_o, stall_o}, 32'h3);
    check("R6 cwp held", 32'(cwp_o), 1);
    call_i = 1; step(); call_i = 0;  // R3 ignored while stalled
    check("R3 call ignored in stall", {29'd0, cwp_o}, 1);
    check("R6 unf still held", {31'd0, unf_trap_o}, 1);
    fill_ack_i = 1; step(); fill_ack_i = 0;
    check("R6 swp back", 32'(swp_o), 0);
    check("R6 trap dropped", {31'd0, unf_trap_o}, 0);
    step();
    check("R6 return completes", 32'(cwp_o), 0);
    check("R6 stall falls", {31'd0, stall_o}, 0);
    rd0_addr_i = 5'd1; step();
    check("R1 shared reg unchanged", rd0_data_o, 32'h600D_0001);

    done = 1;
    finish_run();
  end

endmodule